// File: doc/BRIEF.md
# Byte-Lane Addressed Switch Input Port

This block is a sixteen-bit switch input port on a processor I/O bus whose data path is split into an even byte lane (bits 7..0) and an odd byte lane (bits 15..8). It decodes I/O address bits 7..1 against a fixed port base. It then uses address bit 0 and an active-low bus-high-enable to decide which lanes answer. It places the switch levels on those lanes only while the active-low I/O read strobe is low.

The same hardware answers in three ways. It is a byte port at the even address (base 30h), a byte port at the odd address (31h), or one word port at 30h when both lanes are requested together. Address bits above bit 7 take no part in the decode. Tristate buffers are modelled as one output-enable per lane. The data bits of a lane that is not enabled are held at zero.

Top module: `lane_switch_port`

## Requirements
- R1: A lane is enabled only when address bits 7..1 equal 7'b0011000; any other value there leaves both `lane_en_o` bits at 0.
- R2: Address bits 15..8 have no effect on `lane_en_o` or `data_o`.
- R3: With a matching address, read strobe low, address bit 0 = 0 and `bhe_ni` = 1, `lane_en_o` = 2'b01 and `data_o[7:0]` equals `sw_i[7:0]` (byte read at 30h).
- R4: With a matching address, read strobe low, address bit 0 = 1 and `bhe_ni` = 0, `lane_en_o` = 2'b10 and `data_o[15:8]` equals `sw_i[15:8]` (byte read at 31h).
- R5: With a matching address, read strobe low, address bit 0 = 0 and `bhe_ni` = 0, `lane_en_o` = 2'b11 and `data_o` equals `sw_i` (word read at 30h).
- R6: While `ior_ni` is 1, `lane_en_o` is 2'b00 for every address, `bhe_ni` and switch value.
- R7: The data bits of a lane whose enable is 0 are 0. Bit 0 of `lane_en_o` is the even lane (`data_o[7:0]`) and bit 1 is the odd lane (`data_o[15:8]`).
- R8: Address bit 0 = 1 with `bhe_ni` = 1 enables no lane.
- R9: No storage is kept. A change of `sw_i` during an active read appears on `data_o` with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr_i | input | 16 | I/O address; bits 7..1 decoded, bit 0 selects the even lane |
| bhe_ni | input | 1 | Active-low bus-high-enable, requests the odd lane |
| ior_ni | input | 1 | Active-low I/O read strobe |
| sw_i | input | 16 | Switch levels |
| data_o | output | 16 | Read data, zero on released lanes |
| lane_en_o | output | 2 | Per-lane drive enable, bit 0 even lane, bit 1 odd lane |

## Verification
Each of the four combinations of address bit 0 and bus-high-enable is applied at the matching address. This separates the even-byte, odd-byte and word answers from the combination that selects nothing. Each mismatching value of bits 7..1, including each single-bit miss, shows that every bit of the decode is compared. Random upper address bits and a strobe held high show that those inputs cannot open a lane. Opposite switch patterns per byte, and switches toggled in the middle of a read, show that the lanes are not swapped and that nothing is latched.

// File: rtl/lane_port_pkg.sv
package lane_port_pkg;
  parameter int unsigned ADDR_W    = 16;
  parameter int unsigned LANE_W    = 8;
  parameter int unsigned NUM_LANES = 2;
  parameter int unsigned DATA_W    = LANE_W * NUM_LANES;
  parameter int unsigned DEC_MSB   = 7;
  parameter logic [DEC_MSB:1] PORT_BASE = 7'b0011000;

  typedef logic [NUM_LANES-1:0] lane_mask_t;
endpackage

// File: rtl/lane_addr_decode.sv
module lane_addr_decode
  import lane_port_pkg::*;
#(
  parameter int unsigned        A_W   = ADDR_W,
  parameter int unsigned        MSB   = DEC_MSB,
  parameter logic [DEC_MSB:1]   BASE  = PORT_BASE
) (
  input  logic [A_W-1:0] addr_i,
  output logic           hit_o
);
  logic [A_W-1:0] unused_addr;
  always_comb begin
    unused_addr = addr_i;
    hit_o = (addr_i[MSB:1] == BASE);
  end
endmodule

// File: rtl/lane_select.sv
module lane_select
  import lane_port_pkg::*;
(
  input  logic       hit_i,
  input  logic       a0_i,
  input  logic       bhe_ni,
  input  logic       ior_ni,
  output lane_mask_t en_o
);
  // even lane follows A0 low, odd lane follows BHE low
  always_comb begin
    en_o    = '0;
    en_o[0] = hit_i & ~ior_ni & ~a0_i;
    en_o[1] = hit_i & ~ior_ni & ~bhe_ni;
  end

  always_comb begin
    if (!ior_ni && hit_i && a0_i && bhe_ni)
      a_r8_no_lane: assert (en_o == '0);
  end
endmodule

// File: rtl/lane_gate.sv
module lane_gate
  import lane_port_pkg::*;
(
  input  lane_mask_t          en_i,
  input  logic [DATA_W-1:0]   sw_i,
  output logic [DATA_W-1:0]   data_o
);
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    always_comb begin
      data_o[g*LANE_W +: LANE_W] = en_i[g] ? sw_i[g*LANE_W +: LANE_W] : '0;
    end
    always_comb begin
      if (!en_i[g])
        a_r7_released_zero: assert (data_o[g*LANE_W +: LANE_W] == '0);
      else
        a_r9_passthru: assert (data_o[g*LANE_W +: LANE_W] == sw_i[g*LANE_W +: LANE_W]);
    end
  end
endmodule

// File: rtl/lane_switch_port.sv
module lane_switch_port
  import lane_port_pkg::*;
(
  input  logic [15:0] addr_i,
  input  logic        bhe_ni,
  input  logic        ior_ni,
  input  logic [15:0] sw_i,
  output logic [15:0] data_o,
  output logic [1:0]  lane_en_o
);
  logic       hit;
  lane_mask_t en;

  lane_addr_decode u_dec (
    .addr_i (addr_i),
    .hit_o  (hit)
  );

  lane_select u_sel (
    .hit_i  (hit),
    .a0_i   (addr_i[0]),
    .bhe_ni (bhe_ni),
    .ior_ni (ior_ni),
    .en_o   (en)
  );

  lane_gate u_gate (
    .en_i   (en),
    .sw_i   (sw_i),
    .data_o (data_o)
  );

  assign lane_en_o = en;

  always_comb begin
    if (ior_ni)
      a_r6_idle_no_drive: assert (lane_en_o == 2'b00);
    if (lane_en_o != 2'b00)
      a_r1_decode_match: assert (addr_i[7:1] == 7'b0011000);
  end
endmodule

// File: tb/lane_switch_port_tb.sv
module lane_switch_port_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = 16'h0000;
  logic        bhe_ni = 1'b1;
  logic        ior_ni = 1'b1;
  logic [15:0] sw_i = 16'h0000;
  logic [15:0] data_o;
  logic [1:0]  lane_en_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lane_switch_port u_dut (
    .addr_i    (addr_i),
    .bhe_ni    (bhe_ni),
    .ior_ni    (ior_ni),
    .sw_i      (sw_i),
    .data_o    (data_o),
    .lane_en_o (lane_en_o)
  );

  function automatic logic [1:0] exp_en(logic [15:0] a, logic bhe, logic ior);
    logic [1:0] e;
    e = 2'b00;
    if (!ior && a[7:1] == 7'b0011000) begin
      e[0] = ~a[0];
      e[1] = ~bhe;
    end
    return e;
  endfunction

  function automatic logic [15:0] exp_data(logic [1:0] e, logic [15:0] s);
    return {e[1] ? s[15:8] : 8'h00, e[0] ? s[7:0] : 8'h00};
  endfunction

  task automatic check(string req);
    logic [1:0]  ee;
    logic [15:0] ed;
    ee = exp_en(addr_i, bhe_ni, ior_ni);
    ed = exp_data(ee, sw_i);
    checks++;
    if (lane_en_o !== ee || data_o !== ed) begin
      errors++;
      $display("FAIL %s en=%b data=%h expected en=%b data=%h", req, lane_en_o, data_o, ee, ed);
    end
  endtask

  task automatic apply(logic [15:0] a, logic bhe, logic ior, logic [15:0] s, string req);
    @(negedge clk);
    addr_i = a; bhe_ni = bhe; ior_ni = ior; sw_i = s;
    #1;
    check(req);
  endtask

  task automatic t_reset_state();
    #1;
    check("R6 reset idle");
  endtask

  task automatic t_even_byte();
    apply(16'h0030, 1'b1, 1'b0, 16'hA55A, "R3 even byte");
    apply(16'h0030, 1'b1, 1'b0, 16'h00FF, "R3 even byte ones");
  endtask

  task automatic t_odd_byte();
    apply(16'h0031, 1'b0, 1'b0, 16'h3CC3, "R4 odd byte");
    apply(16'h0031, 1'b0, 1'b0, 16'hFF00, "R4 odd byte ones");
  endtask

  task automatic t_word();
    apply(16'h0030, 1'b0, 1'b0, 16'h1234, "R5 word");
    apply(16'h0030, 1'b0, 1'b0, 16'hFFFF, "R5 word all ones");
  endtask

  task automatic t_no_lane();
    apply(16'h0031, 1'b1, 1'b0, 16'hFFFF, "R8 odd without bhe");
  endtask

  task automatic t_decode_miss();
    for (int b = 1; b < 8; b++) begin
      apply(16'h0030 ^ (16'h1 << b), 1'b0, 1'b0, 16'hFFFF, "R1 single bit miss");
    end
    apply(16'h0032, 1'b0, 1'b0, 16'hFFFF, "R1 adjacent port");
  endtask

  task automatic t_high_bits();
    for (int i = 0; i < 8; i++) begin
      logic [7:0] hi;
      hi = 8'($urandom);
      apply({hi, 8'h30}, 1'b0, 1'b0, 16'hBEEF, "R2 high bits word");
      apply({hi, 8'h31}, 1'b0, 1'b0, 16'hCAFE, "R2 high bits odd");
    end
  endtask

  task automatic t_strobe_high();
    apply(16'h0030, 1'b0, 1'b1, 16'hFFFF, "R6 write or idle");
    apply(16'hFF31, 1'b0, 1'b1, 16'hFFFF, "R6 idle odd");
    apply(16'h0030, 1'b1, 1'b1, 16'h5555, "R7 idle zero data");
  endtask

  task automatic t_live_switches();
    apply(16'h0030, 1'b0, 1'b0, 16'h0F0F, "R9 start");
    #2 sw_i = 16'hF0F0; #1 check("R9 mid read change");
    #1 sw_i = 16'h8001; #1 check("R9 second change");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog en=%b data=%h expected completion", lane_en_o, data_o);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    t_even_byte();
    t_odd_byte();
    t_word();
    t_no_lane();
    t_decode_miss();
    t_high_bits();
    t_strobe_high();
    t_live_switches();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule